// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Two-Entry Status Queue

This block receives asynchronous serial characters on a single line. The line is oversampled at sixteen times the bit rate, and the 16x strobe is supplied on an input. The block recognises a start bit, takes either eight or nine data bits least-significant first, and samples the stop bit. Each finished character goes into a small queue. A queue entry holds the data byte, the ninth bit and a framing-error flag, so the status that the consumer sees always belongs to the character at the head of the queue.

The consumer watches the pending flag, or the interrupt output when it is enabled, and reads the head entry from the output ports. A one-cycle pop strobe then advances the queue. If a character finishes while the queue is full, that character is discarded and a sticky overrun flag is raised. While the flag is set, no later character enters the queue. The only way to clear it is to drop the receive enable and raise it again. Dropping the enable also empties the queue and resets the sampler.

The sampler is a state machine with four states:
- `S_IDLE` waits for a falling edge on the line, and `S_IDLE -> S_START` is taken on that edge.
- `S_START` checks the line at sample 8. It takes `S_START -> S_IDLE` if the line is high again, and `S_START -> S_DATA` at the end of the bit time.
- `S_DATA` shifts one voted bit per bit time. It takes `S_DATA -> S_STOP` after the last data bit.
- `S_STOP` votes the stop bit, hands the character to the queue, and takes `S_STOP -> S_IDLE` at once.
- Every state returns to `S_IDLE` while the enable is low.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset `pending`, `irq` and `overrun` are 0.
- R2: In 8-bit mode (`nine_bit`=0) a frame is one low start bit, eight data bits LSB first, and one stop bit, each lasting 16 ticks of `os_tick`. The byte appears on `rx_data`, `rx_ninth` reads 0, and `pending` becomes 1 after the stop bit is sampled.
- R3: In 9-bit mode (`nine_bit`=1) a ninth data bit follows bit 7. It is reported on `rx_ninth` together with its byte.
- R4: A character whose stop bit is voted 0 is stored with its framing flag set, and `rx_ferr` reads 1 while it is at the head.
- R5: The queue holds two characters in arrival order. A `pop` makes the data, ninth bit and framing flag of the next entry visible. When the last entry is popped, `pending` clears.
- R6: If a stop bit is sampled while both entries are full, the character is dropped, the queue is unchanged, and `overrun` sets. While `overrun` is 1, no character enters the queue, even after the queue has been emptied.
- R7: Driving `rx_en` low clears `overrun` and empties the queue. Characters sent while `rx_en` is low are not received.
- R8: A low pulse that ends before sample 8 of the start bit is not taken as a character.
- R9: `irq` is 1 exactly when `pending` and `int_en` are both 1.
- R10: A `pop` while the queue is empty has no effect, and the next character is received normally.
- R11: Each bit is the majority of samples 7, 8 and 9. A wrong level lasting one tick near mid-bit does not change the received value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; low flushes and resets the receiver and clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_in | input | 1 | Serial input line, idle high |
| pop | input | 1 | Removes the head entry of the queue |
| int_en | input | 1 | Interrupt enable |
| rx_data | output | 8 | Data byte of the head entry (0 when empty) |
| rx_ninth | output | 1 | Ninth bit of the head entry (0 when empty) |
| rx_ferr | output | 1 | Framing-error flag of the head entry (0 when empty) |
| pending | output | 1 | Queue holds at least one character |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A sampler state or bit counter that goes wrong shows up in the same frame. The character arrives shifted, is missing, or carries a false framing flag, and this is visible at `rx_data`/`rx_ferr` within one character time. A queue pointer or count error shows on the next pop as swapped order or a wrong `pending`. An overrun flag that fails to stick, or that clears on its own, is exposed by the next character whether or not it lands in the queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              ferr;
        logic              ninth;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      nine,
    input  logic      tick,
    input  logic      rx_s,
    output logic      done,
    output rx_entry_t word
);
    localparam int CW    = $clog2(OSR);
    localparam int MID   = OSR / 2 - 1;
    localparam int VOTE  = OSR / 2;
    localparam int SHW   = BYTE_W + 1;

    rx_state_e      state, nxt;
    logic [CW-1:0]  cnt;
    logic [3:0]     bit_cnt;
    logic           rx_prev;
    logic [1:0]     hist;
    logic [SHW-1:0] shreg;
    logic           vote;
    logic [3:0]     last_bit;

    assign vote     = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
    assign last_bit = nine ? 4'd8 : 4'd7;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (tick && rx_prev && !rx_s) nxt = S_START;
            S_START: begin
                if (tick && cnt == CW'(MID) && rx_s) nxt = S_IDLE;
                else if (tick && cnt == CW'(OSR-1))  nxt = S_DATA;
            end
            S_DATA:  if (tick && cnt == CW'(OSR-1) && bit_cnt == last_bit) nxt = S_STOP;
            S_STOP:  if (tick && cnt == CW'(VOTE)) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (!en) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_cnt <= '0;
            rx_prev <= 1'b1;
            hist    <= 2'b11;
            shreg   <= '0;
        end else if (!en) begin
            cnt     <= '0;
            bit_cnt <= '0;
            rx_prev <= 1'b1;
            hist    <= 2'b11;
            shreg   <= '0;
        end else if (tick) begin
            rx_prev <= rx_s;
            hist    <= {hist[0], rx_s};
            if (state == S_IDLE || nxt != state) cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
            if (state == S_START) bit_cnt <= '0;
            if (state == S_DATA) begin
                if (cnt == CW'(VOTE))  shreg   <= {vote, shreg[SHW-1:1]};
                if (cnt == CW'(OSR-1)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        done       = en && tick && state == S_STOP && cnt == CW'(VOTE);
        word.ferr  = !vote;
        word.ninth = nine ? shreg[SHW-1] : 1'b0;
        word.data  = nine ? shreg[BYTE_W-1:0] : shreg[SHW-1:1];
    end
endmodule

// File: rtl/rx_queue.sv
module rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = count == '0;
    assign full    = count == (AW+1)'(DEPTH);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mem[i] <= '0;
            else if (do_push && wr_ptr == AW'(i))     mem[i] <= din;
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              pop,
    input  logic              int_en,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              rx_ferr,
    output logic              pending,
    output logic              irq,
    output logic              overrun
);
    logic      rx_s, done, q_empty, q_full;
    rx_entry_t word, head;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    rx_sampler #(.OSR(OSR)) u_samp (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .nine(nine_bit),
        .tick(os_tick), .rx_s(rx_s), .done(done), .word(word)
    );

    rx_queue #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en),
        .push(done && !overrun), .din(word), .pop(pop),
        .head(head), .empty(q_empty), .full(q_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              overrun <= 1'b0;
        else if (!rx_en)         overrun <= 1'b0;
        else if (done && q_full) overrun <= 1'b1;
    end

    always_comb begin
        pending  = !q_empty;
        irq      = pending && int_en;
        rx_data  = pending ? head.data  : '0;
        rx_ninth = pending ? head.ninth : 1'b0;
        rx_ferr  = pending ? head.ferr  : 1'b0;
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic int_en,
    input logic pending,
    input logic irq,
    input logic overrun
);
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && overrun) |=> overrun);                         // R6
    AST_OVR_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && overrun && !pending) |=> !pending);            // R6
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!overrun && !pending));                      // R7
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);                                        // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);                                       // R9
endmodule

bind uart_rx_fifo uart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .int_en(int_en),
    .pending(pending), .irq(irq), .overrun(overrun)
);

// File: tb/uart_rx_fifo_test.sv
module uart_rx_fifo_test;
    localparam int BIT_CYC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       pop = 1'b0;
    logic       int_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth, rx_ferr, pending, irq, overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    uart_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
        .os_tick(os_tick), .rx_in(rx_in), .pop(pop), .int_en(int_en),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_ferr(rx_ferr),
        .pending(pending), .irq(irq), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [8:0] v, input logic stop_v, input int glitch_bit);
        int nb;
        nb = nine_bit ? 9 : 8;
        hold(1'b0, BIT_CYC);
        for (int i = 0; i < nb; i++) begin
            if (i == glitch_bit) begin
                hold(v[i], 14);
                hold(~v[i], 2);
                hold(v[i], 16);
            end else begin
                hold(v[i], BIT_CYC);
            end
        end
        hold(stop_v, BIT_CYC);
        hold(1'b1, BIT_CYC);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pending", pending, 0);
        check("R1 irq", irq, 0);
        check("R1 overrun", overrun, 0);
    endtask

    task automatic t_eight_bit();
        nine_bit = 1'b0;
        send_char(9'h0A5, 1'b1, -1);
        check("R2 pending", pending, 1);
        check("R2 data", rx_data, 8'hA5);
        check("R2 ninth", rx_ninth, 0);
        check("R2 ferr", rx_ferr, 0);
        do_pop();
        check("R5 empty after pop", pending, 0);
    endtask

    task automatic t_nine_bit();
        nine_bit = 1'b1;
        send_char(9'h13C, 1'b1, -1);
        check("R3 data", rx_data, 8'h3C);
        check("R3 ninth", rx_ninth, 1);
        do_pop();
        nine_bit = 1'b0;
    endtask

    task automatic t_order_ferr();
        send_char(9'h011, 1'b0, -1);
        send_char(9'h0E2, 1'b1, -1);
        check("R4 ferr head", rx_ferr, 1);
        check("R5 head data", rx_data, 8'h11);
        do_pop();
        check("R5 second data", rx_data, 8'hE2);
        check("R5 second ferr", rx_ferr, 0);
        check("R5 still pending", pending, 1);
        do_pop();
        check("R5 drained", pending, 0);
    endtask

    task automatic t_irq();
        int_en = 1'b0;
        send_char(9'h055, 1'b1, -1);
        check("R9 masked", irq, 0);
        int_en = 1'b1;
        @(negedge clk);
        check("R9 raised", irq, 1);
        do_pop();
        check("R9 cleared", irq, 0);
        int_en = 1'b0;
    endtask

    task automatic t_pop_empty();
        do_pop();
        check("R10 pending", pending, 0);
        send_char(9'h07E, 1'b1, -1);
        check("R10 data", rx_data, 8'h7E);
        do_pop();
    endtask

    task automatic t_glitch();
        hold(1'b0, 6);
        hold(1'b1, 4 * BIT_CYC);
        check("R8 no char", pending, 0);
        send_char(9'h0C3, 1'b1, 3);
        check("R11 voted", rx_data, 8'hC3);
        do_pop();
    endtask

    task automatic t_overrun();
        send_char(9'h001, 1'b1, -1);
        send_char(9'h002, 1'b1, -1);
        check("R6 no ovr yet", overrun, 0);
        send_char(9'h003, 1'b1, -1);
        check("R6 ovr set", overrun, 1);
        check("R6 head kept", rx_data, 8'h01);
        do_pop();
        check("R6 second kept", rx_data, 8'h02);
        do_pop();
        check("R6 third dropped", pending, 0);
        send_char(9'h004, 1'b1, -1);
        check("R6 blocked", pending, 0);
        check("R6 sticky", overrun, 1);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 ovr cleared", overrun, 0);
        send_char(9'h099, 1'b1, -1);
        check("R7 disabled ignores", pending, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_char(9'h05A, 1'b1, -1);
        check("R7 reenabled data", rx_data, 8'h5A);
        do_pop();
    endtask

    task automatic t_flush();
        send_char(9'h066, 1'b1, -1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 flush", pending, 0);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_eight_bit();
        t_nine_bit();
        t_order_ferr();
        t_irq();
        t_pop_empty();
        t_glitch();
        t_overrun();
        t_flush();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule